// File: doc/BRIEF.md
# APB General-Purpose Output Stage With Pin Overrides

This block is a sixteen-pin output stage sitting on an APB slave. Software sets a level register and a driver-control register. Each pin's tri-state driver is switched by its own control bit. A control bit of 1 parks the driver in high impedance, and 0 turns it on. The block presents every pad as two signals: a level and a drive-enable. The pad cell outside the block does the actual tri-stating.

The upper eight pins can be taken over by other on-chip sources, selected by control signals that arrive as plain inputs:
- Pin 15 can carry a first clock output.
- Pin 14 can carry a second clock output.
- Pins 13 to 9 can carry, as one group, a five-bit debug bus.
- Pin 8 can carry a test-mode data bit.

An overridden pin is always driven with its override source, whatever its register bits hold. Pins 7 to 0 have no override.

The APB side always answers at once. The slave tracks bus phases with a small state machine:
- `ST_IDLE`: nothing selected.
- `ST_SETUP`: select high and enable low.
- `ST_ACCESS`: select and enable both high.

Its transitions are:
- IDLE→SETUP on a fresh select.
- SETUP→ACCESS when enable rises.
- ACCESS→SETUP on a back-to-back select.
- ACCESS→IDLE otherwise.
- SETUP→IDLE if select is dropped.

Top module: `gpo_stage`

## Requirements
- R1: After reset the level register (offset 0x0) reads 0x00000000 and the driver-control register (offset 0x4) reads 0x00007FFF.
- R2: Only bits 15:0 of both registers exist. Bits 31:16 always read as zero, and writing them has no effect.
- R3: A read of any offset other than 0x0 or 0x4 returns zero, and a write there changes neither register.
- R4: `pready` is always 1 and `pslverr` is always 0.
- R5: For a pin without an active override, `pad_oe[i]` is 1 exactly when driver-control bit i is 0. Bit value 1 means high impedance.
- R6: Pins 7:0 always present level-register bit i on `pad_out[i]`.
- R7: While `clk_sel_hi` is 1, pin 15 is driven with `clk_src_hi`. Otherwise it carries level bit 15 under control bit 15.
- R8: While `clk_sel_lo` is 1, pin 14 is driven with `clk_src_lo`. Otherwise it carries level bit 14 under control bit 14.
- R9: While `dbg_sel` is 1, pins 13:9 are driven with `dbg_bus[4:0]`, where bus bit 0 goes to pin 9. Otherwise they carry level bits 13:9 under control bits 13:9.
- R10: While `test_mode` is 1, pin 8 is driven with `test_data`. Otherwise it carries level bit 8 under control bit 8.
- R11: A register changes only on a clock edge where `psel`, `penable` and `pwrite` are all 1. A setup phase alone, or a read, leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | APB clock, rising edge |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during a selected read |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| clk_sel_hi | input | 1 | Hands pin 15 to `clk_src_hi` |
| clk_src_hi | input | 1 | First clock-output source |
| clk_sel_lo | input | 1 | Hands pin 14 to `clk_src_lo` |
| clk_src_lo | input | 1 | Second clock-output source |
| dbg_sel | input | 1 | Hands pins 13:9 to the debug bus |
| dbg_bus | input | 5 | Debug bus |
| test_mode | input | 1 | Hands pin 8 to `test_data` |
| test_data | input | 1 | Test-mode data bit |
| pad_out | output | 16 | Level presented to each pad |
| pad_oe | output | 16 | 1 = pad driver on |

## Verification
The pad outputs are tried in several ways:
- With every override held low, so each pin's level and drive come from the two registers alone.
- With each override raised alone, which shows that one group is steered while its neighbours keep their register values.
- Under random mixes of all overrides and random register contents, where a mis-wired pin index or a swapped control shows up as a single-bit mismatch.

The register side is tried in three ways:
- Writes with the upper halfword set, which separates implemented bits from reserved ones.
- Accesses to unmapped offsets, which separate decoded locations from the rest.
- A setup phase held with write high but no enable, which separates a real access from a bus merely selecting the block.

// File: rtl/gpo_pkg.sv
package gpo_pkg;

    // How a pin chooses the level it presents
    typedef enum logic [2:0] {
        PK_PLAIN,
        PK_CLK_HI,
        PK_CLK_LO,
        PK_DBG,
        PK_TEST
    } pin_kind_e;

    // APB phase tracking
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACCESS
    } apb_state_e;

    localparam int unsigned NPINS      = 16;
    localparam int unsigned CLK_HI_PIN = 15;
    localparam int unsigned CLK_LO_PIN = 14;
    localparam int unsigned DBG_LSB    = 9;
    localparam int unsigned DBG_W      = 5;
    localparam int unsigned TEST_PIN   = 8;

    function automatic pin_kind_e pin_kind(input int unsigned idx);
        if (idx == CLK_HI_PIN)                             return PK_CLK_HI;
        else if (idx == CLK_LO_PIN)                        return PK_CLK_LO;
        else if (idx >= DBG_LSB && idx < DBG_LSB + DBG_W)  return PK_DBG;
        else if (idx == TEST_PIN)                          return PK_TEST;
        else                                               return PK_PLAIN;
    endfunction

endpackage

// File: rtl/gpo_apb_fsm.sv
module gpo_apb_fsm
    import gpo_pkg::*;
(
    input  logic pclk,
    input  logic presetn,
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    output logic wr_stb,
    output logic rd_en
);

    apb_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (psel && !penable) state_d = ST_SETUP;
            ST_SETUP:  if (!psel)            state_d = ST_IDLE;
                       else if (penable)     state_d = ST_ACCESS;
            ST_ACCESS: if (psel && !penable) state_d = ST_SETUP;
                       else                  state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) state_q <= ST_IDLE;
        else          state_q <= state_d;
    end

    always_comb begin
        wr_stb = psel && penable && pwrite;
        rd_en  = psel && !pwrite;
    end

    // R11: an access phase only ever follows a setup phase
    p_setup_before_access_r11: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable) |-> (state_q == ST_SETUP));

endmodule

// File: rtl/gpo_regs.sv
module gpo_regs
    import gpo_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NBITS    = NPINS,
    parameter logic [NBITS-1:0] LVL_RST = '0,
    parameter logic [NBITS-1:0] CTL_RST = 16'h7FFF
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              wr_stb,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic [NBITS-1:0]  lvl_q,
    output logic [NBITS-1:0]  ctl_q
);

    localparam logic [ADDR_W-1:0] OFF_LVL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_CTL = ADDR_W'(4);

    logic hit_lvl, hit_ctl;
    logic unused_hi;

    assign hit_lvl   = (paddr == OFF_LVL);
    assign hit_ctl   = (paddr == OFF_CTL);
    assign unused_hi = ^pwdata[DATA_W-1:NBITS];

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            lvl_q <= LVL_RST;
            ctl_q <= CTL_RST;
        end else if (wr_stb) begin
            if (hit_lvl) lvl_q <= pwdata[NBITS-1:0];
            if (hit_ctl) ctl_q <= pwdata[NBITS-1:0];
        end
    end

    always_comb begin
        prdata = '0;
        if (rd_en) begin
            if (hit_lvl)      prdata[NBITS-1:0] = lvl_q;
            else if (hit_ctl) prdata[NBITS-1:0] = ctl_q;
        end
    end

    // R11: registers hold when no write access happens
    p_hold_without_write_r11: assert property (@(posedge pclk) disable iff (!presetn)
        !wr_stb |=> ($stable(lvl_q) && $stable(ctl_q)));

    // R3: writes to unmapped offsets change nothing
    p_unmapped_write_r3: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_stb && !hit_lvl && !hit_ctl) |=> ($stable(lvl_q) && $stable(ctl_q)));

    // R2: the reserved upper half never reads as anything but zero
    p_reserved_zero_r2: assert property (@(posedge pclk) disable iff (!presetn)
        prdata[DATA_W-1:NBITS] == '0);

endmodule

// File: rtl/gpo_pad_mux.sv
module gpo_pad_mux
    import gpo_pkg::*;
(
    input  logic [NPINS-1:0] lvl_q,
    input  logic [NPINS-1:0] ctl_q,
    input  logic             clk_sel_hi,
    input  logic             clk_src_hi,
    input  logic             clk_sel_lo,
    input  logic             clk_src_lo,
    input  logic             dbg_sel,
    input  logic [DBG_W-1:0] dbg_bus,
    input  logic             test_mode,
    input  logic             test_data,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        localparam pin_kind_e KIND = pin_kind(i);
        logic ovr_on, ovr_val;

        if (KIND == PK_CLK_HI) begin : g_chi
            assign ovr_on  = clk_sel_hi;
            assign ovr_val = clk_src_hi;
        end else if (KIND == PK_CLK_LO) begin : g_clo
            assign ovr_on  = clk_sel_lo;
            assign ovr_val = clk_src_lo;
        end else if (KIND == PK_DBG) begin : g_dbg
            assign ovr_on  = dbg_sel;
            assign ovr_val = dbg_bus[i-DBG_LSB];
        end else if (KIND == PK_TEST) begin : g_tst
            assign ovr_on  = test_mode;
            assign ovr_val = test_data;
        end else begin : g_plain
            assign ovr_on  = 1'b0;
            assign ovr_val = 1'b0;
        end

        assign pad_out[i] = ovr_on ? ovr_val : lvl_q[i];
        assign pad_oe[i]  = ovr_on | ~ctl_q[i];
    end

    // R7: clock override takes pin 15 fully
    always_comb begin
        if (clk_sel_hi) p_clk_hi_r7: assert (pad_oe[CLK_HI_PIN] && pad_out[CLK_HI_PIN] == clk_src_hi);
    end

    // R9: debug group follows the bus
    always_comb begin
        if (dbg_sel) p_dbg_group_r9: assert (pad_out[DBG_LSB +: DBG_W] == dbg_bus && &pad_oe[DBG_LSB +: DBG_W]);
    end

    // R6: low pins always present the level register
    always_comb begin
        p_low_pins_r6: assert (pad_out[TEST_PIN-1:0] == lvl_q[TEST_PIN-1:0]);
    end

endmodule

// File: rtl/gpo_stage.sv
module gpo_stage
    import gpo_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              clk_sel_hi,
    input  logic              clk_src_hi,
    input  logic              clk_sel_lo,
    input  logic              clk_src_lo,
    input  logic              dbg_sel,
    input  logic [DBG_W-1:0]  dbg_bus,
    input  logic              test_mode,
    input  logic              test_data,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);

    logic wr_stb, rd_en;
    logic [NPINS-1:0] lvl_q, ctl_q;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    gpo_apb_fsm u_fsm (
        .pclk    (pclk),
        .presetn (presetn),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .wr_stb  (wr_stb),
        .rd_en   (rd_en)
    );

    gpo_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .pclk    (pclk),
        .presetn (presetn),
        .wr_stb  (wr_stb),
        .rd_en   (rd_en),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .lvl_q   (lvl_q),
        .ctl_q   (ctl_q)
    );

    gpo_pad_mux u_mux (
        .lvl_q      (lvl_q),
        .ctl_q      (ctl_q),
        .clk_sel_hi (clk_sel_hi),
        .clk_src_hi (clk_src_hi),
        .clk_sel_lo (clk_sel_lo),
        .clk_src_lo (clk_src_lo),
        .dbg_sel    (dbg_sel),
        .dbg_bus    (dbg_bus),
        .test_mode  (test_mode),
        .test_data  (test_data),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

    // R4: zero wait states and no error response
    p_ready_no_err_r4: assert property (@(posedge pclk) disable iff (!presetn)
        pready && !pslverr);

    // R3: selected reads of unmapped offsets return zero
    p_unmapped_read_r3: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && !pwrite && paddr != ADDR_W'(0) && paddr != ADDR_W'(4)) |-> prdata == '0);

endmodule

// File: tb/gpo_stage_bench.sv
module gpo_stage_bench;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        clk_sel_hi = 0, clk_src_hi = 0, clk_sel_lo = 0, clk_src_lo = 0;
    logic        dbg_sel = 0, test_mode = 0, test_data = 0;
    logic [4:0]  dbg_bus = '0;
    logic [15:0] pad_out, pad_oe;

    int unsigned n_tests = 0, n_fail = 0;
    logic [15:0] m_lvl = 16'h0000, m_ctl = 16'h7FFF;

    always #4 pclk = ~pclk;

    gpo_stage u_gpo_stage (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr),
        .clk_sel_hi(clk_sel_hi), .clk_src_hi(clk_src_hi),
        .clk_sel_lo(clk_sel_lo), .clk_src_lo(clk_src_lo),
        .dbg_sel(dbg_sel), .dbg_bus(dbg_bus),
        .test_mode(test_mode), .test_data(test_data),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_pads(input logic want_oe);
        logic [15:0] v, e;
        v = m_lvl;
        e = ~m_ctl;
        if (clk_sel_hi) begin v[15] = clk_src_hi; e[15] = 1'b1; end
        if (clk_sel_lo) begin v[14] = clk_src_lo; e[14] = 1'b1; end
        if (dbg_sel)    begin v[13:9] = dbg_bus;  e[13:9] = 5'h1F; end
        if (test_mode)  begin v[8] = test_data;   e[8] = 1'b1; end
        return want_oe ? {16'h0, e} : {16'h0, v};
    endfunction

    task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1;
        @(negedge pclk);
        psel = 0; penable = 0; pwrite = 0;
        if (a == 12'h0) m_lvl = d[15:0];
        if (a == 12'h4) m_ctl = d[15:0];
    endtask

    task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge pclk);
        penable = 1;
        #1 d = prdata;
        @(negedge pclk);
        psel = 0; penable = 0;
    endtask

    task automatic check_pads(input string req);
        #1;
        check({req, " pad_out"}, {16'h0, pad_out}, exp_pads(1'b0));
        check({req, " pad_oe"},  {16'h0, pad_oe},  exp_pads(1'b1));
    endtask

    task automatic clear_ovr();
        clk_sel_hi = 0; clk_sel_lo = 0; dbg_sel = 0; test_mode = 0;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [11:0] offs [4];
        void'($urandom(32'd20240611));
        offs[0] = 12'h0; offs[1] = 12'h4; offs[2] = 12'h8; offs[3] = 12'hFFC;

        repeat (3) @(negedge pclk);
        presetn = 1;

        // R1 reset values
        apb_read(12'h0, rd); check("R1 level reset", rd, 32'h0);
        apb_read(12'h4, rd); check("R1 control reset", rd, 32'h0000_7FFF);
        // R5 reset drive pattern: only pin 15 on
        check_pads("R5 reset");
        check("R4 pready", {31'h0, pready}, 32'h1);
        check("R4 pslverr", {31'h0, pslverr}, 32'h0);

        // R2 reserved bits
        apb_write(12'h0, 32'hFFFF_A5C3);
        apb_read(12'h0, rd); check("R2 level upper", rd, 32'h0000_A5C3);
        apb_write(12'h4, 32'hABCD_0F0F);
        apb_read(12'h4, rd); check("R2 control upper", rd, 32'h0000_0F0F);

        // R3 unmapped
        apb_write(12'h8, 32'h1234_5678);
        apb_write(12'h40, 32'hFFFF_FFFF);
        apb_read(12'h8, rd); check("R3 unmapped read", rd, 32'h0);
        apb_read(12'h0, rd); check("R3 level untouched", rd, 32'h0000_A5C3);
        apb_read(12'h4, rd); check("R3 control untouched", rd, 32'h0000_0F0F);

        // R11 setup phase alone does nothing
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 1; paddr = 12'h0; pwdata = 32'h0000_1111;
        repeat (3) @(negedge pclk);
        psel = 0; pwrite = 0;
        apb_read(12'h0, rd); check("R11 setup only", rd, 32'h0000_A5C3);

        // R5 R6 plain driving, all overrides off
        apb_write(12'h4, 32'h0000_0000);
        check_pads("R6 all driven");
        apb_write(12'h4, 32'h0000_00FF);
        check_pads("R5 low high-z");

        // single overrides
        apb_write(12'h0, 32'h0000_0000);
        apb_write(12'h4, 32'h0000_FFFF);
        clk_sel_hi = 1; clk_src_hi = 1; check_pads("R7 clk hi");
        clk_src_hi = 0; check_pads("R7 clk hi low");
        clear_ovr(); clk_sel_lo = 1; clk_src_lo = 1; check_pads("R8 clk lo");
        clear_ovr(); dbg_sel = 1; dbg_bus = 5'b10110; check_pads("R9 debug");
        dbg_bus = 5'b00001; check_pads("R9 debug lsb");
        clear_ovr(); test_mode = 1; test_data = 1; check_pads("R10 test");
        clear_ovr(); check_pads("R7 R8 R9 R10 released");

        // random mix
        for (int k = 0; k < 300; k++) begin
            logic [11:0] a;
            logic [31:0] d;
            a = offs[$urandom_range(0, 3)];
            d = $urandom;
            apb_write(a, d);
            {clk_sel_hi, clk_src_hi, clk_sel_lo, clk_src_lo} = 4'($urandom);
            {dbg_sel, test_mode, test_data} = 3'($urandom);
            dbg_bus = 5'($urandom);
            check_pads("R5 R6 R7 R8 R9 R10 random");
            if (k % 10 == 0) begin
                apb_read(a, rd);
                check("R2 R3 random read", rd,
                      (a == 12'h0) ? {16'h0, m_lvl} : (a == 12'h4) ? {16'h0, m_ctl} : 32'h0);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule